// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial memory. A fast system clock samples the open-drain clock and data lines. The block recognises start and stop conditions, takes in a control byte and a word address, and then does one of two things. It collects data bytes for a write, or it sends bytes from its internal byte array back to the master. The block can only pull the data line low: its single output is an active-high pull-down enable, and an outside open-drain pad turns that enable into the bus level.

A write lands first in a 16-byte page latch, indexed by the low four address bits. When a stop arrives after at least one whole data byte, a modelled programming cycle of `PROG_CYCLES` system clocks moves the latched bytes into the array. For the whole of that cycle the slave acknowledges nothing. A read starts either at the current address or at an address set beforehand by a write that sends only the address. The address then advances after each byte the master acknowledges.

Top module: `tw_mem_slave`

## Requirements
- R1: A command starts only with a start condition, which is SDA falling while SCL is high. A byte clocked in without a preceding start is not acknowledged.
- R2: The control byte is `1010` in bits 7..4, block-select bits in bits 3..1 (the low `BLK_W` of them are used) and the direction in bit 0, where 0 means write. Any other top nibble gets no acknowledge, and the slave stays silent until the next start.
- R3: After each byte the slave accepts, it pulls SDA low (`sda_oe_o`=1) for the whole high phase of the ninth SCL pulse. It releases SDA on the following SCL fall.
- R4: A write sends a word-address byte and then data bytes. These bytes go to consecutive addresses inside the 16-byte page of that address. Only the low 4 address bits advance, and they wrap from 15 to 0.
- R5: When more than 16 data bytes arrive, each page position keeps the last byte written to it, so the oldest bytes are overwritten first.
- R6: A stop starts the programming cycle only if at least one complete data byte was received since the last start. A stop after only the address starts no cycle.
- R7: While the programming cycle of `PROG_CYCLES` clocks runs, the slave acknowledges nothing, not even its own control byte. Once the cycle ends, acknowledges resume.
- R8: A read sends bytes MSB first from the current address. The address advances by one after each byte the master acknowledges. Sending an address by write, then a repeated start and a read control byte, reads from that address.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and keeps it released until the next start.
- R10: A start seen in the middle of a byte abandons that byte and the write in progress. A stop that follows then starts no programming cycle and changes no array content.
- R11: SDA is driven only as a pull-down enable. `sda_oe_o` is low out of reset and changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
The hardest cases to reach from the pins are the programming-cycle lockout and the abandoned write. The bench issues a fresh start and control byte right after a write's stop, so the control byte falls inside the busy window and must get no acknowledge. It repeats the same control byte after the window has passed and expects an acknowledge. For the abandoned write, the bench stops clocking after four data bits, forces a repeated start and then a stop. It then checks two things: an immediate control byte is acknowledged, which shows no cycle began, and the target address still reads back zero. Page-latch overflow is reached by sending twenty bytes from a mid-page address, and the full page is read back and compared against a latch model kept in the bench.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CTRL, ST_CTRL_ACK, ST_ADDR, ST_ADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } tw_state_e;
  localparam logic [3:0] CTRL_TAG = 4'b1010;
endpackage

// File: rtl/tw_bus_sync.sv
module tw_bus_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign scl_o      = scl_ff[1];
  assign sda_o      = sda_ff[1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // data edge with clock held high on both samples
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/tw_page_buf.sv
module tw_page_buf #(
  parameter int PAGE_AW = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               ptr_ld_i,
  input  logic [PAGE_AW-1:0] ptr_i,
  input  logic               push_i,
  input  logic [7:0]         data_i,
  input  logic [PAGE_AW-1:0] idx_i,
  output logic [7:0]         data_o,
  output logic               valid_o
);
  localparam int DEPTH = 1 << PAGE_AW;

  logic [PAGE_AW-1:0] ptr_q;
  logic [7:0]         ent_q [DEPTH];
  logic [DEPTH-1:0]   vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (ptr_ld_i) ptr_q <= ptr_i;
    else if (push_i)   ptr_q <= ptr_q + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[g] <= '0;
        vld_q[g] <= 1'b0;
      end else if (clr_i) begin
        vld_q[g] <= 1'b0;
      end else if (push_i && ptr_q == PAGE_AW'(g)) begin
        ent_q[g] <= data_i;
        vld_q[g] <= 1'b1;
      end
    end
  end

  assign data_o  = ent_q[idx_i];
  assign valid_o = vld_q[idx_i];
endmodule

// File: rtl/tw_prog_timer.sv
module tw_prog_timer #(
  parameter int PROG_CYCLES = 300,
  parameter int PAGE_AW     = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic               busy_o,
  output logic               step_o,
  output logic [PAGE_AW-1:0] idx_o
);
  localparam int             CW    = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0]  LAST  = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0]  SLOTS = CW'(1 << PAGE_AW);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign step_o = busy_q && (cnt_q < SLOTS);
  assign idx_o  = cnt_q[PAGE_AW-1:0];
endmodule

// File: rtl/tw_mem_array.sv
module tw_mem_array #(
  parameter int AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
  import tw_pkg::*;
#(
  parameter int BLK_W       = 1,
  parameter int PAGE_AW     = 4,
  parameter int PROG_CYCLES = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int AW = BLK_W + 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic busy, step;
  logic [PAGE_AW-1:0] step_idx;
  logic [7:0] buf_data, rd_data;
  logic buf_valid, mem_we;
  logic [AW-1:0] rd_addr;

  tw_state_e       state_q;
  logic [3:0]      bitn_q;
  logic [7:0]      sreg_q, txreg_q;
  logic            oe_q, is_rd_q, wr_armed_q, mack_q;
  logic [BLK_W-1:0] blk_q;
  logic [AW-1:0]   cur_addr_q;

  logic byte_end, buf_load, buf_push, prog_go;

  tw_bus_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  assign byte_end = scl_fall && (bitn_q == 4'd8) && !start_c && !stop_c;
  assign buf_load = byte_end && (state_q == ST_ADDR);
  assign buf_push = byte_end && (state_q == ST_WDATA);
  assign prog_go  = stop_c && wr_armed_q && !busy;

  tw_page_buf #(.PAGE_AW(PAGE_AW)) u_buf (
    .clk_i, .rst_ni,
    .clr_i(buf_load), .ptr_ld_i(buf_load), .ptr_i(sreg_q[PAGE_AW-1:0]),
    .push_i(buf_push), .data_i(sreg_q),
    .idx_i(step_idx), .data_o(buf_data), .valid_o(buf_valid)
  );

  tw_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .PAGE_AW(PAGE_AW)) u_timer (
    .clk_i, .rst_ni, .start_i(prog_go),
    .busy_o(busy), .step_o(step), .idx_o(step_idx)
  );

  assign mem_we  = step && buf_valid;
  assign rd_addr = (state_q == ST_RACK) ? cur_addr_q + 1'b1 : cur_addr_q;

  tw_mem_array #(.AW(AW)) u_mem (
    .clk_i, .rst_ni, .we_i(mem_we),
    .waddr_i({cur_addr_q[AW-1:PAGE_AW], step_idx}), .wdata_i(buf_data),
    .raddr_i(rd_addr), .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bitn_q     <= '0;
      sreg_q     <= '0;
      txreg_q    <= '0;
      oe_q       <= 1'b0;
      is_rd_q    <= 1'b0;
      wr_armed_q <= 1'b0;
      mack_q     <= 1'b0;
      blk_q      <= '0;
      cur_addr_q <= '0;
    end else if (start_c) begin
      state_q    <= ST_CTRL;
      bitn_q     <= '0;
      oe_q       <= 1'b0;
      wr_armed_q <= 1'b0;
    end else if (stop_c) begin
      state_q    <= ST_IDLE;
      oe_q       <= 1'b0;
      wr_armed_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          if (scl_rise && bitn_q != 4'd8) begin
            sreg_q <= {sreg_q[6:0], sda_s};
            bitn_q <= bitn_q + 4'd1;
          end else if (byte_end) begin
            bitn_q <= '0;
            if (state_q == ST_CTRL) begin
              if (sreg_q[7:4] == CTRL_TAG && !busy) begin
                oe_q    <= 1'b1;
                blk_q   <= sreg_q[BLK_W:1];
                is_rd_q <= sreg_q[0];
                state_q <= ST_CTRL_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_ADDR) begin
              oe_q       <= 1'b1;
              cur_addr_q <= {blk_q, sreg_q};
              state_q    <= ST_ADDR_ACK;
            end else begin
              oe_q       <= 1'b1;
              wr_armed_q <= 1'b1;
              cur_addr_q <= {cur_addr_q[AW-1:PAGE_AW], cur_addr_q[PAGE_AW-1:0] + 1'b1};
              state_q    <= ST_WDATA_ACK;
            end
          end
        end
        ST_CTRL_ACK: if (scl_fall) begin
          bitn_q <= '0;
          if (is_rd_q) begin
            txreg_q <= rd_data;
            oe_q    <= ~rd_data[7];
            state_q <= ST_RDATA;
          end else begin
            oe_q    <= 1'b0;
            state_q <= ST_ADDR;
          end
        end
        ST_ADDR_ACK, ST_WDATA_ACK: if (scl_fall) begin
          oe_q    <= 1'b0;
          state_q <= ST_WDATA;
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitn_q <= bitn_q + 4'd1;
          end else if (scl_fall) begin
            if (bitn_q == 4'd8) begin
              bitn_q  <= '0;
              oe_q    <= 1'b0;
              state_q <= ST_RACK;
            end else begin
              txreg_q <= {txreg_q[6:0], 1'b0};
              oe_q    <= ~txreg_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              cur_addr_q <= rd_addr;
              txreg_q    <= rd_data;
              oe_q       <= ~rd_data[7];
              state_q    <= ST_RDATA;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  a_r7_silent_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_oe_o);
  a_r11_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);
  a_r6_prog_after_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(stop_c && wr_armed_q));
  a_r6_write_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> busy);
  a_r3_ack_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o && scl_s && !start_c && !stop_c &&
     (state_q == ST_CTRL_ACK || state_q == ST_ADDR_ACK || state_q == ST_WDATA_ACK))
    |=> sda_oe_o);
endmodule

// File: tb/tw_mem_slave_test.sv
module tw_mem_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int PROG       = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;

  assign sda_bus = m_sda & ~sda_oe;

  tw_mem_slave #(.BLK_W(1), .PAGE_AW(4), .PROG_CYCLES(PROG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int oe_viol = 0;
  logic [7:0] model [512];
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  logic [7:0] wdat [32];
  logic       done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wclk(Q);
    scl = 1'b1;   wclk(Q);
    m_sda = 1'b0; wclk(Q);
    scl = 1'b0;   wclk(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wclk(Q);
    scl = 1'b1;   wclk(Q);
    m_sda = 1'b1; wclk(Q);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    wclk(Q); m_sda = b; wclk(Q);
    scl = 1'b1; wclk(Q);
    seen = sda_bus; wclk(Q);
    scl = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) clk_bit(b[i], s);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = (s == 1'b0);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  // page latch model for R4/R5 writes
  task automatic wr_txn(input int blk, input int addr, input int n, input string tag);
    bit ack;
    logic [7:0] lat [16];
    bit vld [16];
    int p;
    bus_start;
    send_byte(8'hA0 | 8'(blk << 1), ack);
    check(ack, {tag, " R3 ctrl ack"}, ack, 1);
    send_byte(8'(addr), ack);
    check(ack, {tag, " R3 addr ack"}, ack, 1);
    for (int k = 0; k < 16; k++) vld[k] = 1'b0;
    p = addr & 15;
    for (int k = 0; k < n; k++) begin
      send_byte(wdat[k], ack);
      check(ack, {tag, " R3 data ack"}, ack, 1);
      lat[p] = wdat[k]; vld[p] = 1'b1; p = (p + 1) & 15;
    end
    bus_stop;
    for (int k = 0; k < 16; k++)
      if (vld[k]) model[(blk << 8) | (addr & 8'hF0) | k] = lat[k];
  endtask

  task automatic rd_txn(input int blk, input int addr, input int n, input string tag);
    bit ack;
    logic [7:0] b;
    logic s;
    int nseen;
    bus_start;
    send_byte(8'hA0 | 8'(blk << 1), ack);
    check(ack, {tag, " R8 ctrl ack"}, ack, 1);
    send_byte(8'(addr), ack);
    check(ack, {tag, " R8 addr ack"}, ack, 1);
    bus_start;
    send_byte(8'hA1 | 8'(blk << 1), ack);
    check(ack, {tag, " R8 read ctrl ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model[((blk << 8) | addr) + k]);
      recv_byte(k != n - 1, b);
      got_q.push_back(b);
    end
    // R9: after the master's nack the slave stays released
    nseen = 0;
    for (int k = 0; k < 9; k++) begin
      clk_bit(1'b1, s);
      if (s == 1'b0) nseen++;
    end
    check(nseen == 0, {tag, " R9 released after nack"}, nseen, 0);
    bus_stop;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        check(g == e, "R8 read data", g, e);
      end
    end
  end

  // R11 monitor: enable may move only while SCL low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl) oe_viol++;
    oe_prev <= sda_oe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    wclk(5);
    check(sda_oe == 1'b0, "R11 reset enable", sda_oe, 0);
    rst_n = 1'b1;
    wclk(5);

    // R1: byte without start
    scl = 1'b0; wclk(Q);
    send_byte(8'hA0, ack);
    check(!ack, "R1 no ack without start", ack, 0);
    bus_stop;

    // R4 basic write, then R7 lockout
    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33;
    wr_txn(0, 8'h10, 3, "wr1");
    bus_start;
    send_byte(8'hA0, ack);
    check(!ack, "R7 no ack while busy", ack, 0);
    bus_stop;
    wclk(PROG + 50);
    bus_start;
    send_byte(8'hA0, ack);
    check(ack, "R7 ack after cycle", ack, 1);
    bus_stop;

    rd_txn(0, 8'h10, 4, "rd1");

    // R4 wrap inside page
    wdat[0] = 8'hA5; wdat[1] = 8'h5A; wdat[2] = 8'hC3; wdat[3] = 8'h3C;
    wr_txn(0, 8'h0E, 4, "R4 wrap");
    wclk(PROG + 50);
    rd_txn(0, 8'h00, 16, "R4 page");

    // R5 overflow in block 1
    for (int k = 0; k < 20; k++) wdat[k] = 8'(8'h40 + k);
    wr_txn(1, 8'h23, 20, "R5 ovf");
    wclk(PROG + 50);
    rd_txn(1, 8'h20, 16, "R5 page");

    // R2 bad control byte and silence afterwards
    bus_start;
    send_byte(8'hB0, ack);
    check(!ack, "R2 bad ctrl nack", ack, 0);
    send_byte(8'h00, ack);
    check(!ack, "R2 silent after bad ctrl", ack, 0);
    bus_stop;

    // R6 address-only write starts no cycle
    bus_start;
    send_byte(8'hA0, ack);
    send_byte(8'h40, ack);
    check(ack, "R6 addr ack", ack, 1);
    bus_stop;
    bus_start;
    send_byte(8'hA0, ack);
    check(ack, "R6 no cycle after addr only", ack, 1);
    bus_stop;

    // R10 start mid byte abandons write
    bus_start;
    send_byte(8'hA0, ack);
    send_byte(8'h50, ack);
    send_bits(8'h99, 4);
    bus_start;
    bus_stop;
    bus_start;
    send_byte(8'hA0, ack);
    check(ack, "R10 no cycle after abort", ack, 1);
    bus_stop;
    rd_txn(0, 8'h50, 1, "R10 unchanged");

    wclk(20);
    check(oe_viol == 0, "R11 enable moves only with SCL low", oe_viol, 0);
    check(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule